// File: doc/BRIEF.md
# Pseudorandom Remote-Control Code Generator and Detector

This block lets one station close a relay at a distant station by sending a pseudorandom bit pattern over the data link. On the sending side, a push-button switches the transmit data path from user data to the output of an 8-bit linear feedback shift register. A per-channel configuration value selects which register stages feed back into the register.

On the receiving side, every received bit is checked against the bit that the same feedback rule predicts from the eight bits received before it. A run of correct predictions is counted. When the run is long enough, the block raises a "code present" indicator. After a further qualifying stretch of correct bits, it closes the relay output. A single wrong bit, or a pause in the bit stream, clears the detector, and a complete new run is then needed.

Both sides advance only on a bit strobe, so the block runs from the system clock at any bit rate below it.

Top module: `rc_code_detector`

## Requirements
- R1: While `tx_button` is high, each `tx_bit_en` strobe shifts the 8-bit generator state left by one. The new bit enters at bit 0 as the XOR of the state bits selected by `taps`, where `taps` bit i selects state bit i. `tx_data_out` presents that new bit. While `tx_button` is low, the state is reloaded with the nonzero `SEED` (default 8'h01).
- R2: While `tx_button` is low, `tx_data_out` equals `user_tx_data`.
- R3: The first 8 received bits after reset, after a mismatch or after an idle timeout only fill the 8-bit history and are never compared.
- R4: Once the history is full, each received bit is compared with the XOR of the history bits selected by `taps`, where history bit 0 is the newest bit. A match adds one to the run of correct bits.
- R5: `code_active` rises in the cycle after the strobe that completes 256 consecutive correct compared bits, and not earlier.
- R6: `relay_closed` rises after a further `HOLD_BITS` (default 32) correct bits beyond the 256-bit threshold. `relay_closed` is never high without `code_active`.
- R7: A single mismatching bit clears `code_active` and `relay_closed` in the next cycle. A fresh fill and a fresh run of 256 correct bits are then required.
- R8: When `IDLE_CYC` (default 64) clock cycles pass with no `rx_bit_en`, the detector clears completely. Shorter gaps leave its state unchanged.
- R9: A stream generated with a different tap set from the configured `taps` does not raise `code_active`.
- R10: After reset, `code_active` and `relay_closed` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| taps | input | 8 | Feedback tap mask, shared by generator and detector |
| tx_button | input | 1 | High selects the pseudorandom code for transmission |
| tx_bit_en | input | 1 | Transmit bit strobe |
| user_tx_data | input | 1 | Normal transmit data |
| tx_data_out | output | 1 | Bit sent to the modulator |
| rx_bit_en | input | 1 | Receive bit strobe |
| rx_bit | input | 1 | Received data bit |
| code_active | output | 1 | Code recognised (drives the ready indicator to red) |
| relay_closed | output | 1 | Relay drive |

## Verification
On every cycle, the assertions check the following:
- the relay never leads the code indicator;
- a mismatch always clears both outputs in the next cycle;
- neither output can rise without a bit strobe in the cycle before;
- the run count holds still during short gaps;
- the generator always restarts from its seed.

The exact thresholds need the bench's scenarios. Only they can show that the indicator comes at exactly 256 correct bits and not at 255, that the relay comes at exactly 288, that the 8-bit fill follows an error, that the idle timeout works, and that a foreign tap set is rejected. A loopback of the generator into the detector shows that the two sides agree on bit order.

// File: rtl/rc_code_detector.sv
module rc_code_detector #(
  parameter int          W         = 8,
  parameter int          THRESH    = 256,
  parameter int          HOLD_BITS = 32,
  parameter int          IDLE_CYC  = 64,
  parameter logic [W-1:0] SEED     = 8'h01
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] taps,
  input  logic         tx_button,
  input  logic         tx_bit_en,
  input  logic         user_tx_data,
  output logic         tx_data_out,
  input  logic         rx_bit_en,
  input  logic         rx_bit,
  output logic         code_active,
  output logic         relay_closed
);
  localparam int RUN_MAX = THRESH + HOLD_BITS;
  localparam int RW      = $clog2(RUN_MAX + 1);
  localparam int IW      = $clog2(IDLE_CYC + 1);
  localparam int FW      = $clog2(W + 1);

  logic [W-1:0]  gen, hist;
  logic [FW-1:0] fill_cnt;
  logic [RW-1:0] run;
  logic [IW-1:0] idle;
  logic          fb, pred, filled, miss, timeout, busy;

  // generator
  assign fb          = ^(gen & taps);
  assign tx_data_out = tx_button ? fb : user_tx_data;

  always_ff @(posedge clk) begin
    if (!rst_n || !tx_button) gen <= SEED;
    else if (tx_bit_en)       gen <= {gen[W-2:0], fb};
  end

  // detector
  assign pred    = ^(hist & taps);
  assign filled  = (fill_cnt == FW'(W));
  assign miss    = rx_bit_en && filled && (rx_bit != pred);
  assign busy    = (fill_cnt != '0) || (run != '0);
  assign timeout = !rx_bit_en && busy && (idle == IW'(IDLE_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist     <= '0;
      fill_cnt <= '0;
      run      <= '0;
      idle     <= '0;
    end else if (rx_bit_en) begin
      idle <= '0;
      if (miss) begin
        fill_cnt <= '0;
        run      <= '0;
      end else begin
        hist <= {hist[W-2:0], rx_bit};
        if (!filled)                   fill_cnt <= fill_cnt + 1'b1;
        else if (run != RW'(RUN_MAX))  run      <= run + 1'b1;
      end
    end else if (timeout) begin
      fill_cnt <= '0;
      run      <= '0;
      idle     <= '0;
    end else if (busy) begin
      idle <= idle + 1'b1;
    end
  end

  assign code_active  = (run >= RW'(THRESH));
  assign relay_closed = (run == RW'(RUN_MAX));

  p_relay_needs_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    relay_closed |-> code_active);

  p_miss_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_bit_en && filled && rx_bit != pred) |=> (!code_active && !relay_closed));

  p_code_rise_on_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(code_active) |-> $past(rx_bit_en));

  p_relay_rise_on_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(relay_closed) |-> $past(rx_bit_en));

  p_short_gap_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_bit_en && idle < IW'(IDLE_CYC - 1)) |=> $stable(run));

  p_seed_on_press_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_button) |-> (gen == SEED));

endmodule

// File: tb/rc_code_detector_tb_top.sv
module rc_code_detector_tb_top;
  localparam int IDLE = 64;

  logic clk = 0, rst_n = 0;
  logic [7:0] taps = 8'hB8;
  logic tx_button = 0, tx_bit_en = 0, user_tx_data = 0;
  logic rx_bit_en = 0, rx_bit = 0;
  logic tx_data_out, code_active, relay_closed;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [7:0] hist;

  always #5 clk = ~clk;

  rc_code_detector #(.IDLE_CYC(IDLE)) dut_i (
    .clk(clk), .rst_n(rst_n), .taps(taps), .tx_button(tx_button),
    .tx_bit_en(tx_bit_en), .user_tx_data(user_tx_data), .tx_data_out(tx_data_out),
    .rx_bit_en(rx_bit_en), .rx_bit(rx_bit), .code_active(code_active),
    .relay_closed(relay_closed));

  // {dut_taps, seq_taps, nbits, flip_index(FFFF none), exp_active, exp_relay}
  localparam logic [49:0] VEC [0:6] = '{
    {8'hB8, 8'hB8, 16'd264, 16'hFFFF, 1'b1, 1'b0},
    {8'hB8, 8'hB8, 16'd263, 16'hFFFF, 1'b0, 1'b0},
    {8'hB8, 8'hB8, 16'd296, 16'hFFFF, 1'b1, 1'b1},
    {8'hB8, 8'hB8, 16'd295, 16'hFFFF, 1'b1, 1'b0},
    {8'h8E, 8'h8E, 16'd400, 16'd100,  1'b1, 1'b1},
    {8'h8E, 8'h8E, 16'd360, 16'd100,  1'b0, 1'b0},
    {8'h8E, 8'hB8, 16'd400, 16'hFFFF, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic next_bit(input logic [7:0] t);
    logic b;
    b = ^(hist & t);
    hist = {hist[6:0], b};
    return b;
  endfunction

  task automatic send_bit(input logic b);
    @(negedge clk);
    rx_bit_en = 1; rx_bit = b;
    @(negedge clk);
    rx_bit_en = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    hist = 8'hA5;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic b, m;
    int bad;
    // R10 reset state, R2 pass-through
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R10 active after reset", code_active, 1'b0);
    check("R10 relay after reset", relay_closed, 1'b0);
    user_tx_data = 1; #1;
    check("R2 user data 1", tx_data_out, 1'b1);
    user_tx_data = 0; #1;
    check("R2 user data 0", tx_data_out, 1'b0);

    // table: R3 R4 R5 R6 R7 R9
    foreach (VEC[k]) begin
      do_reset();
      taps = VEC[k][49:42];
      for (int i = 0; i < int'(VEC[k][33:18]); i++) begin
        b = next_bit(VEC[k][41:34]);
        if (i == int'(VEC[k][17:2])) b = ~b;
        send_bit(b);
      end
      check($sformatf("R5/R7/R9 vec%0d code_active", k), code_active, VEC[k][1]);
      check($sformatf("R6/R3 vec%0d relay_closed", k), relay_closed, VEC[k][0]);
    end

    // R8 gap shorter than timeout keeps relay, then R7 single error opens it
    do_reset();
    taps = 8'hB8;
    for (int i = 0; i < 296; i++) send_bit(next_bit(8'hB8));
    repeat (IDLE - 8) @(negedge clk);
    check("R8 short gap keeps relay", relay_closed, 1'b1);
    send_bit(next_bit(8'hB8));
    check("R8 relay after resumed bit", relay_closed, 1'b1);
    b = next_bit(8'hB8);
    send_bit(~b);
    check("R7 mismatch opens relay", relay_closed, 1'b0);
    check("R7 mismatch drops code", code_active, 1'b0);

    // R8 timeout clears
    do_reset();
    for (int i = 0; i < 296; i++) send_bit(next_bit(8'hB8));
    check("R6 relay before timeout", relay_closed, 1'b1);
    repeat (IDLE + 4) @(negedge clk);
    check("R8 timeout opens relay", relay_closed, 1'b0);
    check("R8 timeout drops code", code_active, 1'b0);

    // R1 generator looped into detector
    do_reset();
    taps = 8'h1D;
    @(negedge clk); tx_button = 1;
    hist = 8'h01;
    bad = 0;
    for (int i = 0; i < 296; i++) begin
      @(negedge clk);
      m = next_bit(8'h1D);
      if (tx_data_out !== m) bad++;
      tx_bit_en = 1; rx_bit_en = 1; rx_bit = tx_data_out;
      @(negedge clk);
      tx_bit_en = 0; rx_bit_en = 0;
    end
    check("R1 generator sequence", bad == 0, 1'b1);
    check("R1 loopback closes relay", relay_closed, 1'b1);
    // R1 reseed on new press
    @(negedge clk); tx_button = 0;
    @(negedge clk); tx_button = 1;
    hist = 8'h01;
    #1;
    check("R1 first bit after reseed", tx_data_out, next_bit(8'h1D));

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule